// File: doc/BRIEF.md
# Secondary Interrupt Controller with Per-Line Bypass

This block collects thirty-two level-sensitive interrupt sources and forwards them to a primary interrupt controller. Each source is captured into a raw level word on every clock. An enable mask, which software changes through separate set and clear registers, selects which sources may raise one combined request. That request leaves on output line 31.

Ten sources, 21 through 30, can also be routed around the mask. When the bypass bit of one of these sources is set, its captured level is driven onto the output line with the same number. When the bypass bit is clear, that line is held low. All other output lines stay low. Lines 21 to 30 and line 31 are meant to feed separate inputs of the primary controller.

Software reaches the registers through a plain 32-bit write strobe and a combinational read port over a 4 KB window. The register index is the byte address shifted right by two. A small soft-interrupt register pair works on enable bit 0.

Top module: `sic_top`

## Requirements
- R1: After reset the raw level, enable mask and bypass word are all zero, every output line is low, and every register index reads zero.
- R2: Reading index 1 returns the source inputs as sampled at the most recent rising clock edge.
- R3: A write to index 2 ORs the write data into the enable mask. A write to index 3 clears every enable bit whose data bit is 1. Index 2 reads back the enable mask.
- R4: Index 0 reads the raw level ANDed with the enable mask.
- R5: Output line 31 is high in the cycle after the clock edge at which raw AND enable was non-zero, and low in the cycle after an edge at which it was zero.
- R6: A write to index 8 sets bypass bits, but only bits 21 to 30 (mask 0x7FE00000) can be set. A write to index 9 clears every bypass bit whose data bit is 1. Index 8 reads back the bypass word.
- R7: Each output line i for i in 21..30 carries raw bit i ANDed with bypass bit i, registered one edge after both values. Lines 0 to 20 are always low.
- R8: Index 4 reads raw bit 0 in bit position 0 and zero in all other bits. A non-zero write to index 4 sets enable bit 0. A non-zero write to index 5 clears enable bit 0. A zero write to either index changes nothing.
- R9: Any index other than 0, 1, 2, 3, 4, 5, 8 and 9 reads zero, and writes to those other indices change neither the enable mask nor the bypass word nor any output line. Indices 3, 5 and 9 are write-only and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level-sensitive interrupt sources |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_addr | input | 12 | Byte address inside the 4 KB window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_lines | output | 32 | Line 31 is the combined request, lines 21..30 are bypassed sources |

## Verification
A read result is due in the same cycle as the address, and it already reflects a source change or a write committed at the preceding rising edge. Output lines are due one edge later than the register state they derive from, so a source change shows on a line two edges after it is driven. The bench keeps a behavioural model that moves forward on the same edges and compares lines and read data at every falling edge. Directed checks on line 31 and the bypass lines sample both the cycle just after a write, where the old value is still expected, and the cycle after that, where the new value is expected.

// File: rtl/sic_pkg.sv
package sic_pkg;

    // register indices (byte offset >> 2)
    localparam logic [31:0] IDX_STATUS   = 32'd0;
    localparam logic [31:0] IDX_RAW      = 32'd1;
    localparam logic [31:0] IDX_EN_SET   = 32'd2;
    localparam logic [31:0] IDX_EN_CLR   = 32'd3;
    localparam logic [31:0] IDX_SOFT_SET = 32'd4;
    localparam logic [31:0] IDX_SOFT_CLR = 32'd5;
    localparam logic [31:0] IDX_BYP_SET  = 32'd8;
    localparam logic [31:0] IDX_BYP_CLR  = 32'd9;

    // contiguous mask of ones from bit lo to bit hi
    function automatic logic [63:0] range_mask(input int lo, input int hi);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sic_decode.sv
module sic_decode
    import sic_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 12
) (
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [NSRC-1:0] wdata,
    input  logic [NSRC-1:0] raw,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] byp,
    output logic [NSRC-1:0] en_set,
    output logic [NSRC-1:0] en_clr,
    output logic [NSRC-1:0] byp_set,
    output logic [NSRC-1:0] byp_clr,
    output logic [NSRC-1:0] rdata
);
    localparam int IW = AW - 2;

    logic [IW-1:0]   idx;
    logic [31:0]     idx32;
    logic            wnz;
    logic [NSRC-1:0] bit0;
    logic            unused_low;

    assign idx        = addr[AW-1:2];
    assign idx32      = 32'(idx);
    assign wnz        = |wdata;
    assign bit0       = NSRC'(1);
    assign unused_low = ^addr[1:0];

    always_comb begin
        en_set  = '0;
        en_clr  = '0;
        byp_set = '0;
        byp_clr = '0;
        if (wr) begin
            case (idx32)
                IDX_EN_SET:   en_set  = wdata;
                IDX_EN_CLR:   en_clr  = wdata;
                IDX_SOFT_SET: en_set  = wnz ? bit0 : '0;
                IDX_SOFT_CLR: en_clr  = wnz ? bit0 : '0;
                IDX_BYP_SET:  byp_set = wdata;
                IDX_BYP_CLR:  byp_clr = wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (idx32)
            IDX_STATUS:   rdata = raw & en;
            IDX_RAW:      rdata = raw;
            IDX_EN_SET:   rdata = en;
            IDX_SOFT_SET: rdata = raw & bit0;
            IDX_BYP_SET:  rdata = byp;
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/sic_setclr_bank.sv
module sic_setclr_bank #(
    parameter int              W     = 32,
    parameter logic [W-1:0]    ALLOW = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (ALLOW[i]) begin : g_flop
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          q[i] <= 1'b0;
                else if (set_vec[i]) q[i] <= 1'b1;
                else if (clr_vec[i]) q[i] <= 1'b0;
            end
        end else begin : g_tie
            logic unused_in;
            assign unused_in = set_vec[i] ^ clr_vec[i];
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sic_route.sv
module sic_route #(
    parameter int           NSRC     = 32,
    parameter logic [NSRC-1:0] BYP_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] byp,
    output logic [NSRC-1:0] raw,
    output logic [NSRC-1:0] lines
);
    localparam int COMB = NSRC - 1;

    logic [NSRC-1:0] lines_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw <= '0;
        else        raw <= src;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_line
        if (i == COMB) begin : g_comb
            assign lines_d[i] = |(raw & en);
        end else if (BYP_MASK[i]) begin : g_byp
            assign lines_d[i] = raw[i] & byp[i];
        end else begin : g_low
            assign lines_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lines <= '0;
        else        lines <= lines_d;
    end
endmodule

// File: rtl/sic_top.sv
module sic_top
    import sic_pkg::*;
#(
    parameter int NSRC    = 32,
    parameter int AW      = 12,
    parameter int BYP_LO  = 21,
    parameter int BYP_HI  = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    output logic [NSRC-1:0] irq_lines
);
    localparam logic [63:0]     MASK64   = range_mask(BYP_LO, BYP_HI);
    localparam logic [NSRC-1:0] BYP_MASK = MASK64[NSRC-1:0];

    logic [NSRC-1:0] raw_q, en_q, byp_q;
    logic [NSRC-1:0] en_set, en_clr, byp_set, byp_clr;

    sic_decode #(.NSRC(NSRC), .AW(AW)) u_dec (
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .raw     (raw_q),
        .en      (en_q),
        .byp     (byp_q),
        .en_set  (en_set),
        .en_clr  (en_clr),
        .byp_set (byp_set),
        .byp_clr (byp_clr),
        .rdata   (reg_rdata)
    );

    sic_setclr_bank #(.W(NSRC), .ALLOW('1)) u_en (
        .clk (clk), .rst_n (rst_n),
        .set_vec (en_set), .clr_vec (en_clr), .q (en_q)
    );

    sic_setclr_bank #(.W(NSRC), .ALLOW(BYP_MASK)) u_byp (
        .clk (clk), .rst_n (rst_n),
        .set_vec (byp_set), .clr_vec (byp_clr), .q (byp_q)
    );

    sic_route #(.NSRC(NSRC), .BYP_MASK(BYP_MASK)) u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_i),
        .en    (en_q),
        .byp   (byp_q),
        .raw   (raw_q),
        .lines (irq_lines)
    );
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
    parameter int NSRC   = 32,
    parameter int AW     = 12,
    parameter int BYP_LO = 21,
    parameter int BYP_HI = 30
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_i,
    input logic            reg_wr,
    input logic [AW-1:0]   reg_addr,
    input logic [NSRC-1:0] reg_wdata,
    input logic [NSRC-1:0] reg_rdata,
    input logic [NSRC-1:0] irq_lines,
    input logic [NSRC-1:0] raw_q,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] byp_q
);
    localparam logic [63:0]     M64   = sic_pkg::range_mask(BYP_LO, BYP_HI);
    localparam logic [NSRC-1:0] BMASK = M64[NSRC-1:0];
    localparam logic [NSRC-1:0] LOWM  = ~BMASK & ~(NSRC'(1) << (NSRC - 1));

    logic [31:0] idx;
    logic        known;
    assign idx   = 32'(reg_addr[AW-1:2]);
    assign known = (idx <= 32'd5) || (idx == 32'd8) || (idx == 32'd9);

    assert_raw_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && idx == 32'd1) |-> reg_rdata == $past(src_i));

    assert_en_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && idx == 32'd3) |=> (en_q & $past(reg_wdata)) == '0);

    assert_comb_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_q & en_q) != '0) |=> irq_lines[NSRC-1]);

    assert_comb_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_q & en_q) == '0) |=> !irq_lines[NSRC-1]);

    assert_byp_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_q & ~BMASK) == '0);

    assert_low_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines & LOWM) == '0);

    assert_byp_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_lines & BMASK) == ($past(raw_q & byp_q) & BMASK));

    assert_unlisted_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> reg_rdata == '0);
endmodule

bind sic_top sic_checker #(.NSRC(NSRC), .AW(AW), .BYP_LO(BYP_LO), .BYP_HI(BYP_HI)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_lines (irq_lines),
    .raw_q     (raw_q),
    .en_q      (en_q),
    .byp_q     (byp_q)
);

// File: tb/tb_sic_top.sv
`timescale 1ns/1ps
module tb_sic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, irq_lines;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    sic_top dut (
        .clk (clk), .rst_n (rst_n), .src_i (src_i),
        .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .irq_lines (irq_lines)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_raw, m_en, m_byp, m_lines;

    function automatic logic [31:0] m_read(input int idx);
        case (idx)
            0: return m_raw & m_en;
            1: return m_raw;
            2: return m_en;
            4: return {31'b0, m_raw[0]};
            8: return m_byp;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] m_next_lines();
        logic [31:0] l;
        l = '0;
        for (int i = 21; i <= 30; i++) l[i] = m_raw[i] && m_byp[i];
        l[31] = (m_raw & m_en) != 0;
        return l;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_raw <= '0; m_en <= '0; m_byp <= '0; m_lines <= '0;
        end else begin
            m_lines <= m_next_lines();
            m_raw   <= src_i;
            if (reg_wr) begin
                case (int'(reg_addr >> 2))
                    2: m_en  <= m_en | reg_wdata;
                    3: m_en  <= m_en & ~reg_wdata;
                    4: if (reg_wdata != 0) m_en[0] <= 1'b1;
                    5: if (reg_wdata != 0) m_en[0] <= 1'b0;
                    8: m_byp <= m_byp | (reg_wdata & 32'h7FE0_0000);
                    9: m_byp <= m_byp & ~reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference at each falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5/R7 per-cycle lines", irq_lines, m_lines);
            chk("R2/R4/R9 per-cycle read", reg_rdata, m_read(int'(reg_addr >> 2)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = 12'(idx << 2); reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int idx, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        reg_addr = 12'(idx << 2) | 12'd1;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        src_i = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        #1; rst_n = 1'b1; src_i = '0;
        // R1 reset state
        @(negedge clk);
        chk("R1 lines after reset", irq_lines, 32'h0);
        rd(1, 32'h0, "R1 raw after reset");
        rd(2, 32'h0, "R1 enable after reset");
        rd(8, 32'h0, "R1 bypass after reset");

        // R2 raw capture
        src_i = 32'hA5A5_0001;
        rd(1, 32'hA5A5_0001, "R2 raw follows inputs");
        src_i = 32'h0000_0F0F;
        rd(1, 32'h0000_0F0F, "R2 raw follows new inputs");

        // R3 enable set/clear
        wr(2, 32'h0000_00F0);
        wr(2, 32'h0000_0F00);
        rd(2, 32'h0000_0FF0, "R3 enable OR-accumulates");
        wr(3, 32'h0000_0030);
        rd(2, 32'h0000_0FC0, "R3 enable clear");

        // R4 status and R5 combined line
        rd(0, 32'h0000_0F00, "R4 masked status");
        chk("R5 combined high", irq_lines, 32'h8000_0000);
        wr(3, 32'hFFFF_FFFF);
        chk("R5 combined still high one cycle after clear", irq_lines, 32'h8000_0000);
        @(negedge clk);
        chk("R5 combined low after latency", irq_lines, 32'h0);

        // R6 bypass window
        wr(8, 32'hFFFF_FFFF);
        rd(8, 32'h7FE0_0000, "R6 bypass limited to 21..30");
        wr(9, 32'h0000_0000);
        rd(8, 32'h7FE0_0000, "R6 zero clear keeps bypass");

        // R7 bypass lines
        src_i = 32'h0040_0020;
        settle(2);
        chk("R7 bypassed line 22 only", irq_lines, 32'h0040_0000);
        wr(9, 32'h0040_0000);
        chk("R7 line 22 one cycle after clear", irq_lines, 32'h0040_0000);
        @(negedge clk);
        chk("R7 line 22 low when bypass cleared", irq_lines, 32'h0);
        src_i = 32'hFFFF_FFFF;
        settle(2);
        chk("R7 all other bypass lines follow", irq_lines, 32'h7FA0_0000);
        wr(9, 32'hFFFF_FFFF);
        settle(2);
        chk("R7 lines low with bypass clear", irq_lines, 32'h0);

        // R8 soft register
        src_i = 32'h0000_0001;
        rd(4, 32'h0000_0001, "R8 soft read raw bit 0");
        wr(4, 32'h0);
        rd(2, 32'h0, "R8 zero soft write no effect");
        wr(4, 32'h0000_0100);
        rd(2, 32'h0000_0001, "R8 soft set enable 0");
        settle(1);
        chk("R8 soft enable raises combined", irq_lines, 32'h8000_0000);
        src_i = 32'h0000_0000;
        rd(4, 32'h0, "R8 soft read follows raw 0");
        wr(5, 32'h0);
        rd(2, 32'h0000_0001, "R8 zero soft clear no effect");
        wr(5, 32'h8000_0000);
        rd(2, 32'h0, "R8 soft clear enable 0");

        // R9 unlisted indices
        src_i = 32'h1234_5678;
        wr(2, 32'h0000_0010);
        wr(6, 32'hFFFF_FFFF);
        wr(7, 32'hFFFF_FFFF);
        wr(12, 32'hFFFF_FFFF);
        rd(2, 32'h0000_0010, "R9 unlisted writes leave enable");
        rd(8, 32'h0, "R9 unlisted writes leave bypass");
        settle(1);
        chk("R9 unlisted writes leave lines", irq_lines, 32'h8000_0000);
        rd(6, 32'h0, "R9 read index 6");
        rd(3, 32'h0, "R9 read write-only index 3");
        rd(9, 32'h0, "R9 read write-only index 9");
        rd(1023, 32'h0, "R9 read top index");

        settle(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule